// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that serves a bank of byte-wide registers, 20 locations deep by default. It samples raw SCL and SDA with the system clock and pulls SDA low through an open-drain enable. It recognises START, repeated START and STOP, answers one fixed 7-bit device address and keeps a word pointer that persists between transfers.

A write transfer loads the pointer from its first byte. Every later byte is stored at the pointer, and the pointer then steps forward. A read either follows a pointer write and a repeated START (random read) or starts directly from the stored pointer (current-address read). The pointer steps only when the controller acknowledges a byte. The register storage sits outside the block. It sees the pointer as its address, a write strobe with data, and a read strobe each time a byte is fetched for sending. A one-cycle pulse marks each STOP.

Top module: `i2c_regptr_target`

## Requirements
- R1: The target acknowledges by holding SDA low during the ninth clock after an address byte whose upper seven bits equal 7'b1101000 (0x68). Bit 0 of that byte selects the direction: 0 means write and 1 means read.
- R2: After an address byte that does not match, the target never pulls SDA, writes nothing and leaves the pointer unchanged until the next START or STOP.
- R3: In a write transfer, the first byte after the address loads the pointer. A value of 20 or more loads 0 instead. That byte is acknowledged and is not stored.
- R4: Each later byte of a write transfer is acknowledged and appears on `wr_data` with a one-cycle `wr_en` while `ptr` still holds its address. The pointer then advances during that byte's acknowledge clock.
- R5: Every pointer advance from 19 (13h) wraps to 0, and `ptr` never exceeds 19.
- R6: After a repeated START with the read direction, the target sends the byte at the pointer, MSB first, one bit per SCL low phase.
- R7: When the controller acknowledges a sent byte, the pointer advances and the next byte follows. When the controller does not acknowledge, the target releases SDA and keeps the pointer.
- R8: A read transfer that is not preceded by a pointer write starts at the last pointer value.
- R9: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Each STOP gives exactly one single-cycle pulse on `stop_seen`.
- R10: After reset, SDA is released, `ptr` is 0, and `wr_en`, `rd_en` and `stop_seen` are low.
- R11: `rd_en` pulses for one cycle each time a byte is fetched for sending, and it never occurs together with `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| ptr | output | AW (5) | Word pointer, used as the register address |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Byte to store at `ptr` |
| rd_en | output | 1 | One-cycle strobe when a byte is fetched for sending |
| rd_data | input | 8 | Register contents at `ptr` |
| stop_seen | output | 1 | One-cycle pulse on each STOP |

## Verification
The bench writes three bytes starting at every one of the 20 pointer values, so the writes that run past 13h show whether the pointer wraps to 0 or goes out of range. It then does a random read from every start location, ending with a NACK. A design that advanced the pointer on the NACK would finish one location too far on, and one that kept driving SDA would be caught by the check on the release. A sweep over foreign addresses confirms that such transfers get no acknowledge and change neither storage nor pointer. Pointer bytes of 1Fh and 13h test the clamp on out-of-range values and the top location. A current-address read after all of this shows whether the pointer survived the STOPs.

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NREG = 20,
  parameter int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          rd_en,
  input  logic [7:0]    rd_data,
  output logic          stop_seen
);
  typedef enum logic [2:0] {IDLE, ADDR, AACK, WRX, WACK, TX, MACK, SKIP} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q, cnt;
  logic [7:0] sr;
  logic       rw, first, inc_pend, mack;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire scl_high = scl_q[1] & scl_q[2];
  wire start_c  = scl_high & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_high & ~sda_q[2] & sda_q[1];
  wire [7:0] byte_in = {sr[6:0], sda_q[1]};

  wire [AW-1:0] ptr_next = (ptr == AW'(NREG - 1)) ? '0 : ptr + 1'b1;
  wire [AW-1:0] ptr_load = (byte_in < 8'(NREG)) ? byte_in[AW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= '1;
      sda_q     <= '1;
      st        <= IDLE;
      cnt       <= '0;
      sr        <= '0;
      rw        <= 1'b0;
      first     <= 1'b0;
      inc_pend  <= 1'b0;
      mack      <= 1'b0;
      sda_pull  <= 1'b0;
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      rd_en     <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      scl_q     <= {scl_q[1:0], scl_in};
      sda_q     <= {sda_q[1:0], sda_in};
      wr_en     <= 1'b0;
      rd_en     <= 1'b0;
      stop_seen <= 1'b0;
      if (stop_c) begin
        st        <= IDLE;
        sda_pull  <= 1'b0;
        stop_seen <= 1'b1;
      end else if (start_c) begin
        st       <= ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
        first    <= 1'b1;
      end else begin
        case (st)
          ADDR: if (scl_rise) begin
            sr  <= byte_in;
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              if (byte_in[7:1] == DEV_ADDR) begin
                rw <= byte_in[0];
                st <= AACK;
              end else st <= SKIP;
            end
          end
          AACK: if (scl_fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else if (rw) begin
              sr       <= rd_data;
              rd_en    <= 1'b1;
              sda_pull <= ~rd_data[7];
              st       <= TX;
            end else begin
              sda_pull <= 1'b0;
              st       <= WRX;
            end
          end
          WRX: if (scl_rise) begin
            sr  <= byte_in;
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              if (first) begin
                ptr      <= ptr_load;
                first    <= 1'b0;
                inc_pend <= 1'b0;
              end else begin
                wr_en    <= 1'b1;
                wr_data  <= byte_in;
                inc_pend <= 1'b1;
              end
              st <= WACK;
            end
          end
          WACK: if (scl_fall) begin
            if (!sda_pull) sda_pull <= 1'b1;
            else begin
              sda_pull <= 1'b0;
              st       <= WRX;
            end
          end else if (scl_rise && inc_pend) begin
            ptr      <= ptr_next;
            inc_pend <= 1'b0;
          end
          TX: if (scl_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              sda_pull <= 1'b0;
              st       <= MACK;
            end else begin
              sr       <= {sr[6:0], 1'b0};
              sda_pull <= ~sr[6];
            end
          end
          MACK: if (scl_rise) begin
            mack <= ~sda_q[1];
            if (!sda_q[1]) ptr <= ptr_next;
          end else if (scl_fall) begin
            if (mack) begin
              sr       <= rd_data;
              rd_en    <= 1'b1;
              sda_pull <= ~rd_data[7];
              st       <= TX;
            end else st <= SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regptr_target_chk.sv
module i2c_regptr_target_chk #(
  parameter int NREG = 20,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_pull,
  input logic [AW-1:0] ptr,
  input logic          wr_en,
  input logic          rd_en,
  input logic          stop_seen
);
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < AW'(NREG));
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_ptr_held_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(ptr));
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !stop_seen);
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |-> !sda_pull);
endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .ptr(ptr),
  .wr_en(wr_en), .rd_en(rd_en), .stop_seen(stop_seen)
);

// File: tb/tb_i2c_regptr_target.sv
`timescale 1ns/1ps
module tb_i2c_regptr_target;
  localparam int Q = 6;
  localparam int N = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_pull, wr_en, rd_en, stop_seen;
  logic [4:0] ptr;
  logic [7:0] wr_data, rd_data;
  wire        sda_line = sda_m & ~sda_pull;

  logic [7:0] mem [N];
  logic [7:0] exp_mem [N];
  int exp_ptr = 0, nchk = 0, nbad = 0, nstop = 0, exp_stop = 0, nrd = 0;
  bit done = 1'b0;

  i2c_regptr_target dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .stop_seen(stop_seen)
  );

  assign rd_data = mem[ptr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= 8'(8'hA0 ^ (i * 13));
      nstop <= 0;
      nrd   <= 0;
    end else begin
      if (wr_en) mem[ptr] <= wr_data;
      if (stop_seen) nstop <= nstop + 1;
      if (rd_en) nrd <= nrd + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    exp_stop++;
  endtask

  task automatic xbit(input bit b, output bit v);
    sda_m = b; wq(); scl_m = 1'b1; wq(); v = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) xbit(d[i], s);
    xbit(1'b1, s);
    ack = !s;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] v);
    bit s;
    for (int i = 0; i < 8; i++) begin
      xbit(1'b1, s);
      v = {v[6:0], s};
    end
    xbit(!mack, s);
  endtask

  initial begin
    bit ack;
    logic [7:0] v;
    int r0;
    for (int i = 0; i < N; i++) exp_mem[i] = 8'(8'hA0 ^ (i * 13));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_pull && ptr == 0 && !wr_en && !rd_en && !stop_seen, "R10 reset state",
        {sda_pull, ptr}, 0);

    for (int a = 0; a < 128; a += 3) begin
      bstart();
      wbyte({7'(a), 1'(a)}, ack);
      chk(!ack, "R2 foreign address acked", ack, 0);
      wbyte(8'h07, ack);
      chk(!ack && ptr == exp_ptr, "R2 foreign transfer touched target", {ack, ptr}, exp_ptr);
      bstop();
    end

    for (int a = 0; a < N; a++) begin
      bstart();
      wbyte({7'h68, 1'b0}, ack);
      chk(ack, "R1 write address ack", ack, 1);
      wbyte(8'(a), ack);
      chk(ack && ptr == a, "R3 pointer load", ptr, a);
      for (int k = 0; k < 3; k++) begin
        v = 8'(a * 17 + k * 5 + 1);
        wbyte(v, ack);
        chk(ack, "R4 data ack", ack, 1);
        exp_mem[(a + k) % N] = v;
      end
      bstop();
      exp_ptr = (a + 3) % N;
      chk(ptr == exp_ptr, "R5 pointer after burst", ptr, exp_ptr);
      for (int k = 0; k < 3; k++)
        chk(mem[(a + k) % N] == exp_mem[(a + k) % N], "R4 stored byte",
            mem[(a + k) % N], exp_mem[(a + k) % N]);
    end
    for (int i = 0; i < N; i++)
      chk(mem[i] == exp_mem[i], "R4 full map after sweep", mem[i], exp_mem[i]);

    bstart(); wbyte({7'h68, 1'b0}, ack); wbyte(8'h1F, ack); bstop();
    chk(ack && ptr == 0, "R3 out-of-range pointer clamps to 0", ptr, 0);
    bstart(); wbyte({7'h68, 1'b0}, ack); wbyte(8'h13, ack); bstop();
    chk(ack && ptr == 19, "R3 top pointer value", ptr, 19);
    exp_ptr = 19;

    for (int a = 0; a < N; a++) begin
      bstart();
      wbyte({7'h68, 1'b0}, ack);
      wbyte(8'(a), ack);
      bstart();
      wbyte({7'h68, 1'b1}, ack);
      chk(ack, "R1 read address ack", ack, 1);
      for (int k = 0; k < 3; k++) begin
        rbyte(k < 2, v);
        chk(v == exp_mem[(a + k) % N], k == 0 ? "R6 random read byte" : "R7 sequential read byte",
            v, exp_mem[(a + k) % N]);
      end
      chk(!sda_pull, "R7 SDA released after NACK", sda_pull, 0);
      bstop();
      exp_ptr = (a + 2) % N;
      chk(ptr == exp_ptr, "R7 pointer after NACK", ptr, exp_ptr);
    end

    r0 = nrd;
    bstart();
    wbyte({7'h68, 1'b1}, ack);
    chk(ack, "R8 current read address ack", ack, 1);
    rbyte(1'b1, v);
    chk(v == exp_mem[exp_ptr], "R8 current-address first byte", v, exp_mem[exp_ptr]);
    rbyte(1'b0, v);
    chk(v == exp_mem[(exp_ptr + 1) % N], "R8 current-address second byte", v,
        exp_mem[(exp_ptr + 1) % N]);
    bstop();
    exp_ptr = (exp_ptr + 1) % N;
    chk(ptr == exp_ptr, "R8 pointer after current read", ptr, exp_ptr);
    chk(nrd - r0 == 2, "R11 read fetch count", nrd - r0, 2);
    chk(nstop == exp_stop, "R9 stop pulse count", nstop, exp_stop);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule